// File: doc/BRIEF.md
# Time-of-Day Counter with Access Actions

This block keeps the time of day as a 48-bit seconds count and a 30-bit nanoseconds field. On every clock tick the nanoseconds advance by a nominal increment supplied on an input, optionally nudged by one nanosecond up or down by an external frequency adjuster. When the nanoseconds pass one billion they wrap and the seconds count carries. A one-cycle pulse marks each upward crossing of a whole second.

A host reaches the clock through a small register bus. The bus holds a set of access words: two seconds words, one nanoseconds word and an action field. Writing an action code into the control word triggers that action once, one cycle later. A save action copies the live time into the access words in a single cycle, so the host can read the words one at a time without tearing. A load action replaces the live time with the access words. A delta action adds a signed nanosecond step to the running time, borrowing from or carrying into the seconds as needed.

The nanoseconds field may hold a small negative value of -1 to -16 ns, stored as the top sixteen codes of the 30-bit field. That value means a time just before the current second starts. A negative step larger than that borrows a second instead.

Top module: `tod_counter`

## Requirements
- R1: After reset, liveSec and liveNs are zero, secPulse is low and every bus address reads zero.
- R2: Each cycle with no load, the nanoseconds advance by incNs, plus any correction and delta. Outside the cycle after a load, liveNs holds 0 to 999,999,999 or one of the codes 0x3FFFFFF0 to 0x3FFFFFFF.
- R3: When the advanced nanoseconds reach 1,000,000,000 they wrap by that amount, liveSec increments and secPulse is high for exactly that one cycle.
- R4: The bus map is as follows. Address 0 holds the action in data[1:0], with idle=0, save=1, load=2 and delta=3. Address 1 holds the upper 16 seconds bits in data[15:0]. Address 2 holds the lower 32 seconds bits. Address 3 holds the 30-bit nanoseconds word in data[29:0]. Data bits above a word's width are ignored on write and read as zero.
- R5: A save captures, at its apply edge, the liveSec and liveNs present in the cycle the action field shows save. Those words stay unchanged while the live seconds move on.
- R6: A load sets liveSec to {upper word, lower word} and liveNs to the nanoseconds word at its apply edge. No increment or correction is added in that cycle.
- R7: A delta adds the nanoseconds word, read as a 30-bit two's complement number, to the live time together with that cycle's normal increment. The seconds words have no effect.
- R8: A result from -16 to -1 keeps the seconds and is stored as 2^30 plus the value. A result below -16 adds 1,000,000,000 and decrements the seconds.
- R9: When the nanoseconds move from a negative code to a value of zero or more without a borrow, secPulse is high for that one cycle and the seconds are unchanged.
- R10: The action field returns to idle in the cycle after it was written and reads back as such. Each action takes effect exactly once per write.
- R11: With corrValid high, a tick adds one extra nanosecond when corrSlow is 0 and one fewer when corrSlow is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| incNs | input | INC_W | Nominal nanoseconds added per tick |
| corrValid | input | 1 | Apply a one-nanosecond correction this tick |
| corrSlow | input | 1 | Correction direction: 1 subtracts, 0 adds |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address |
| busWdata | input | DATA_W | Register write data |
| busRdata | output | DATA_W | Register read data (combinational) |
| liveSec | output | SEC_W | Live seconds count |
| liveNs | output | NS_W | Live nanoseconds field |
| secPulse | output | 1 | One-cycle pulse on each upward second crossing |

## Verification
The bench builds the block with its defaults: 48-bit seconds, a 30-bit nanoseconds field, an 8-bit increment, a 16-code negative window and the correction path present. An increment of up to 255 ns per tick would need millions of cycles to reach a second boundary from zero. Loading a time a few ticks short of the boundary brings rollover, snapshot tearing and carry pulses within a handful of cycles. With the increment set to zero the time stands still, so deltas land on exact values such as -16, -17 and the rise from a negative code to a positive one.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;

  // Action codes held in bits [1:0] of the control word.
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_SAVE  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_DELTA = 2'd3
  } todAction_e;

  // Register addresses.
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_SEC_HI = 2'd1;
  localparam logic [1:0] ADDR_SEC_LO = 2'd2;
  localparam logic [1:0] ADDR_NSEC   = 2'd3;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic doSave;
    logic doLoad;
    logic doDelta;
    logic wrSecHi;
    logic wrSecLo;
    logic wrNsec;
  } todStrobe_t;

endpackage

// File: rtl/tod_ctrl.sv
`timescale 1ns/1ps
module tod_ctrl
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWrEn,
  input  logic [1:0] busAddr,
  input  logic [1:0] actCode,
  output todStrobe_t strobe,
  output todAction_e action
);

  todAction_e actReg;
  logic       ctrlWrite;

  assign ctrlWrite = busWrEn && (busAddr == ADDR_CTRL);

  // The action is held for one cycle, applied at the next edge, then cleared.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actReg <= ACT_IDLE;
    end else if (ctrlWrite) begin
      actReg <= todAction_e'(actCode);
    end else begin
      actReg <= ACT_IDLE;
    end
  end

  always_comb begin
    strobe.doSave  = (actReg == ACT_SAVE);
    strobe.doLoad  = (actReg == ACT_LOAD);
    strobe.doDelta = (actReg == ACT_DELTA);
    strobe.wrSecHi = busWrEn && (busAddr == ADDR_SEC_HI);
    strobe.wrSecLo = busWrEn && (busAddr == ADDR_SEC_LO);
    strobe.wrNsec  = busWrEn && (busAddr == ADDR_NSEC);
  end

  assign action = actReg;

  // An action not renewed by a fresh control write is gone one cycle later.
  assert_action_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (actReg != ACT_IDLE && !ctrlWrite) |=> (actReg == ACT_IDLE));

endmodule

// File: rtl/tod_datapath.sv
`timescale 1ns/1ps
module tod_datapath
  import tod_pkg::*;
#(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 30,
  parameter int INC_W      = 8,
  parameter int DATA_W     = 32,
  parameter int NS_PER_SEC = 1000000000,
  parameter int NEG_SPAN   = 16,
  parameter int CORR_EN    = 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  todStrobe_t                strobe,
  input  logic [DATA_W-1:0]         busWdata,
  input  logic [INC_W-1:0]          incNs,
  input  logic                      corrValid,
  input  logic                      corrSlow,
  output logic [SEC_W-1:0]          liveSec,
  output logic [NS_W-1:0]           liveNs,
  output logic                      secPulse,
  output logic [SEC_W-DATA_W-1:0]   shadowSecHi,
  output logic [DATA_W-1:0]         shadowSecLo,
  output logic [NS_W-1:0]           shadowNs
);

  localparam int SEC_HI_W = SEC_W - DATA_W;
  localparam int SUM_W    = NS_W + 2;
  localparam logic [NS_W-1:0]         NEG_FLOOR = NS_W'((2 ** NS_W) - NEG_SPAN);
  localparam logic signed [SUM_W-1:0] ONE_SEC   = SUM_W'(NS_PER_SEC);
  localparam logic signed [SUM_W-1:0] LOW_LIM   = SUM_W'(-NEG_SPAN);

  logic signed [SUM_W-1:0] curNs;
  logic signed [SUM_W-1:0] incTerm;
  logic signed [SUM_W-1:0] corrTerm;
  logic signed [SUM_W-1:0] deltaTerm;
  logic signed [SUM_W-1:0] sum;
  logic                    carry;
  logic                    borrow;
  logic                    pulseNext;
  logic [NS_W-1:0]         nsNext;
  logic [SEC_W-1:0]        secNext;

  // Decode the stored field: the top NEG_SPAN codes stand for -NEG_SPAN..-1.
  always_comb begin
    if (liveNs >= NEG_FLOOR) begin
      curNs = $signed({2'b11, liveNs});
    end else begin
      curNs = $signed({2'b00, liveNs});
    end
  end

  assign incTerm = $signed({{(SUM_W - INC_W){1'b0}}, incNs});

  generate
    if (CORR_EN != 0) begin : g_corr
      always_comb begin
        if (!corrValid) begin
          corrTerm = '0;
        end else if (corrSlow) begin
          corrTerm = {SUM_W{1'b1}};
        end else begin
          corrTerm = SUM_W'(1);
        end
      end
    end else begin : g_noCorr
      assign corrTerm = '0;
    end
  endgenerate

  assign deltaTerm = strobe.doDelta ? $signed({{2{shadowNs[NS_W-1]}}, shadowNs})
                                    : '0;

  assign sum = curNs + incTerm + corrTerm + deltaTerm;

  // Normalize into one second, keeping the small negative window.
  always_comb begin
    carry  = 1'b0;
    borrow = 1'b0;
    nsNext = NS_W'(sum);
    if (sum >= ONE_SEC) begin
      carry  = 1'b1;
      nsNext = NS_W'(sum - ONE_SEC);
    end else if (sum < LOW_LIM) begin
      borrow = 1'b1;
      nsNext = NS_W'(sum + ONE_SEC);
    end
  end

  always_comb begin
    if (carry) begin
      secNext = liveSec + SEC_W'(1);
    end else if (borrow) begin
      secNext = liveSec - SEC_W'(1);
    end else begin
      secNext = liveSec;
    end
  end

  assign pulseNext = carry || ((curNs < 0) && (sum >= 0));

  // Live time.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveSec  <= '0;
      liveNs   <= '0;
      secPulse <= 1'b0;
    end else if (strobe.doLoad) begin
      liveSec  <= {shadowSecHi, shadowSecLo};
      liveNs   <= shadowNs;
      secPulse <= 1'b0;
    end else begin
      liveSec  <= secNext;
      liveNs   <= nsNext;
      secPulse <= pulseNext;
    end
  end

  // Access words; a save overrides any bus write in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowSecHi <= '0;
      shadowSecLo <= '0;
      shadowNs    <= '0;
    end else if (strobe.doSave) begin
      shadowSecHi <= liveSec[SEC_W-1:DATA_W];
      shadowSecLo <= liveSec[DATA_W-1:0];
      shadowNs    <= liveNs;
    end else begin
      if (strobe.wrSecHi) shadowSecHi <= busWdata[SEC_HI_W-1:0];
      if (strobe.wrSecLo) shadowSecLo <= busWdata;
      if (strobe.wrNsec)  shadowNs    <= busWdata[NS_W-1:0];
    end
  end

  assert_save_coherent_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doSave |=> ({shadowSecHi, shadowSecLo} == $past(liveSec)
                       && shadowNs == $past(liveNs)));

  assert_load_applies_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doLoad |=> (liveSec == $past({shadowSecHi, shadowSecLo})
                       && liveNs == $past(shadowNs)));

  assert_ns_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.doLoad |=> (liveNs < NS_W'(NS_PER_SEC) || liveNs >= NEG_FLOOR));

  assert_carry_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.doLoad && secNext == liveSec + SEC_W'(1)) |=> secPulse);

endmodule

// File: rtl/tod_counter.sv
`timescale 1ns/1ps
module tod_counter
  import tod_pkg::*;
#(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 30,
  parameter int INC_W      = 8,
  parameter int DATA_W     = 32,
  parameter int NS_PER_SEC = 1000000000,
  parameter int NEG_SPAN   = 16,
  parameter int CORR_EN    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [INC_W-1:0]  incNs,
  input  logic              corrValid,
  input  logic              corrSlow,
  input  logic              busWrEn,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [SEC_W-1:0]  liveSec,
  output logic [NS_W-1:0]   liveNs,
  output logic              secPulse
);

  localparam int SEC_HI_W = SEC_W - DATA_W;

  todStrobe_t            strobe;
  todAction_e            action;
  logic [SEC_HI_W-1:0]   shadowSecHi;
  logic [DATA_W-1:0]     shadowSecLo;
  logic [NS_W-1:0]       shadowNs;

  tod_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .actCode (busWdata[1:0]),
    .strobe  (strobe),
    .action  (action)
  );

  tod_datapath #(
    .SEC_W      (SEC_W),
    .NS_W       (NS_W),
    .INC_W      (INC_W),
    .DATA_W     (DATA_W),
    .NS_PER_SEC (NS_PER_SEC),
    .NEG_SPAN   (NEG_SPAN),
    .CORR_EN    (CORR_EN)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .busWdata    (busWdata),
    .incNs       (incNs),
    .corrValid   (corrValid),
    .corrSlow    (corrSlow),
    .liveSec     (liveSec),
    .liveNs      (liveNs),
    .secPulse    (secPulse),
    .shadowSecHi (shadowSecHi),
    .shadowSecLo (shadowSecLo),
    .shadowNs    (shadowNs)
  );

  always_comb begin
    case (busAddr)
      ADDR_CTRL:   busRdata = {{(DATA_W - 2){1'b0}}, action};
      ADDR_SEC_HI: busRdata = {{(DATA_W - SEC_HI_W){1'b0}}, shadowSecHi};
      ADDR_SEC_LO: busRdata = shadowSecLo;
      default:     busRdata = {{(DATA_W - NS_W){1'b0}}, shadowNs};
    endcase
  end

endmodule

// File: tb/tod_counter_bench.sv
`timescale 1ns/1ps
module tod_counter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  incNs = '0;
  logic        corrValid = 1'b0;
  logic        corrSlow = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [47:0] liveSec;
  logic [29:0] liveNs;
  logic        secPulse;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tod_counter u_tod_counter (
    .clk(clk), .rstN(rstN), .incNs(incNs), .corrValid(corrValid),
    .corrSlow(corrSlow), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .liveSec(liveSec),
    .liveNs(liveNs), .secPulse(secPulse)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Spec model of one update: returns the next seconds, field and pulse.
  task automatic model(input logic [47:0] s, input logic [29:0] n, input longint add,
                       output logic [47:0] so, output logic [29:0] no, output bit p);
    longint cur, sum;
    cur = (n >= 30'h3FFFFFF0) ? longint'(n) - (longint'(1) << 30) : longint'(n);
    sum = cur + add;
    p = 1'b0;
    if (sum >= 1000000000) begin
      so = s + 48'd1; no = 30'(sum - 1000000000); p = 1'b1;
    end else if (sum < -16) begin
      so = s - 48'd1; no = 30'(sum + 1000000000);
    end else begin
      so = s; no = 30'(sum); p = (cur < 0) && (sum >= 0);
    end
  endtask

  // All bus tasks start and end at a falling edge.
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
    @(negedge clk);
  endtask

  task automatic loadTime(input logic [47:0] s, input logic [29:0] n);
    wr(2'd1, {16'h0, s[47:32]});
    wr(2'd2, s[31:0]);
    wr(2'd3, {2'b00, n});
    wr(2'd0, 32'd2);
    @(negedge clk);
  endtask

  task automatic deltaStep(input longint d, output logic [47:0] s0, output logic [29:0] n0);
    wr(2'd3, 32'(d));
    wr(2'd0, 32'd3);
    s0 = liveSec; n0 = liveNs;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 liveSec", longint'(liveSec), 0);
    chk("R1 liveNs", longint'(liveNs), 0);
    chk("R1 secPulse", longint'(secPulse), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 register", longint'(v), 0);
    end
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(2'd1, 32'hFFFF_ABCD);
    wr(2'd2, 32'h1357_9BDF);
    wr(2'd3, 32'hC000_0123);
    rd(2'd1, v); chk("R4 seconds upper word", longint'(v), 32'h0000_ABCD);
    rd(2'd2, v); chk("R4 seconds lower word", longint'(v), 32'h1357_9BDF);
    rd(2'd3, v); chk("R4 nanoseconds word", longint'(v), 32'h0000_0123);
  endtask

  task automatic t_load();
    logic [31:0] v;
    incNs = 8'd7;
    loadTime(48'h1234_89AB_CDEF, 30'd500);
    chk("R6 load seconds", longint'(liveSec), 48'h1234_89AB_CDEF);
    chk("R6 load nanoseconds without tick", longint'(liveNs), 500);
    rd(2'd0, v);
    chk("R10 action back to idle", longint'(v), 0);
    chk("R2 tick by incNs", longint'(liveNs), 507);
  endtask

  task automatic t_rollover();
    logic [47:0] es; logic [29:0] en; bit ep;
    incNs = 8'd100;
    loadTime(48'd5, 30'd999_999_750);
    es = liveSec; en = liveNs;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      model(es, en, 100, es, en, ep);
      chk("R3 rollover seconds", longint'(liveSec), longint'(es));
      chk("R3 rollover nanoseconds", longint'(liveNs), longint'(en));
      chk("R3 pulse", longint'(secPulse), longint'(ep));
    end
    chk("R3 seconds after carry", longint'(liveSec), 6);
    chk("R3 nanoseconds after carry", longint'(liveNs), 150);
  endtask

  task automatic t_save();
    logic [31:0] hi, lo, ns;
    logic [47:0] s0; logic [29:0] n0;
    incNs = 8'd100;
    // Snapshot taken in the cycle just after rollover.
    loadTime(48'd7, 30'd999_999_900);
    wr(2'd0, 32'd1);
    s0 = liveSec; n0 = liveNs;
    chk("R3 live seconds at capture", longint'(s0), 8);
    chk("R3 live nanoseconds at capture", longint'(n0), 0);
    chk("R3 pulse at capture", longint'(secPulse), 1);
    @(negedge clk);
    rd(2'd1, hi); rd(2'd2, lo); rd(2'd3, ns);
    chk("R5 snapshot after rollover", longint'({hi[15:0], lo}), longint'(s0));
    chk("R5 snapshot nanoseconds", longint'(ns), longint'(n0));
    // Snapshot taken just before rollover, read while live seconds move on.
    loadTime(48'd9, 30'd999_999_700);
    wr(2'd0, 32'd1);
    s0 = liveSec; n0 = liveNs;
    @(negedge clk);
    rd(2'd1, hi); rd(2'd2, lo); rd(2'd3, ns);
    chk("R5 live seconds moved on", longint'(liveSec), 10);
    chk("R5 snapshot before rollover", longint'({hi[15:0], lo}), 9);
    chk("R5 snapshot nanoseconds", longint'(ns), 999_999_800);
    chk("R5 snapshot equals sampled", longint'(ns), longint'(n0));
  endtask

  task automatic t_deltaPos();
    logic [47:0] s0, es; logic [29:0] n0, en; bit ep;
    logic [31:0] v;
    incNs = 8'd0;
    loadTime(48'd20, 30'd999_999_000);
    wr(2'd1, 32'h0000_FFFF);
    wr(2'd2, 32'hFFFF_FFFF);
    deltaStep(5000, s0, n0);
    chk("R7 delta carry seconds", longint'(liveSec), 21);
    chk("R7 delta carry nanoseconds", longint'(liveNs), 4000);
    chk("R3 delta carry pulse", longint'(secPulse), 1);
    repeat (3) @(negedge clk);
    chk("R10 delta applied once seconds", longint'(liveSec), 21);
    chk("R10 delta applied once nanoseconds", longint'(liveNs), 4000);
    rd(2'd0, v);
    chk("R10 control reads idle", longint'(v), 0);
    // Delta combined with a running increment.
    incNs = 8'd3;
    loadTime(48'd60, 30'd1000);
    deltaStep(250, s0, n0);
    model(s0, n0, 253, es, en, ep);
    chk("R7 delta plus increment", longint'(liveNs), longint'(en));
    chk("R7 delta plus increment seconds", longint'(liveSec), 60);
  endtask

  task automatic t_deltaNeg();
    logic [47:0] s0; logic [29:0] n0;
    incNs = 8'd0;
    loadTime(48'd20, 30'd100);
    deltaStep(-1000, s0, n0);
    chk("R8 borrow seconds", longint'(liveSec), 19);
    chk("R8 borrow nanoseconds", longint'(liveNs), 999_999_100);
    loadTime(48'd30, 30'd10);
    deltaStep(-26, s0, n0);
    chk("R8 window edge seconds", longint'(liveSec), 30);
    chk("R8 window edge code", longint'(liveNs), 30'h3FFFFFF0);
    deltaStep(-1, s0, n0);
    chk("R8 below window seconds", longint'(liveSec), 29);
    chk("R8 below window nanoseconds", longint'(liveNs), 999_999_983);
  endtask

  task automatic t_negRise();
    logic [47:0] s0; logic [29:0] n0;
    incNs = 8'd0;
    loadTime(48'd40, 30'd5);
    deltaStep(-10, s0, n0);
    chk("R8 negative code", longint'(liveNs), 30'h3FFFFFFB);
    incNs = 8'd4;
    @(negedge clk);
    chk("R9 still negative", longint'(liveNs), 30'h3FFFFFFF);
    chk("R9 no pulse yet", longint'(secPulse), 0);
    @(negedge clk);
    chk("R9 rise nanoseconds", longint'(liveNs), 3);
    chk("R9 rise pulse", longint'(secPulse), 1);
    chk("R9 seconds unchanged", longint'(liveSec), 40);
  endtask

  task automatic t_corr();
    incNs = 8'd0;
    loadTime(48'd50, 30'd1000);
    corrValid = 1'b1; corrSlow = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 fast correction", longint'(liveNs), 1003);
    corrSlow = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 slow correction", longint'(liveNs), 1001);
    corrValid = 1'b0;
    @(negedge clk);
    chk("R11 no correction", longint'(liveNs), 1001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regmap();
    t_load();
    t_rollover();
    t_save();
    t_deltaPos();
    t_deltaNeg();
    t_negRise();
    t_corr();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule